// File: doc/BRIEF.md
# Prescaled Match-Capture Timer

A 32-bit timer/counter that sits behind a simple synchronous register port on a peripheral bus. A programmable prescaler divides the peripheral clock. Each time the prescaler wraps, the main counter advances by one. Four compare registers watch the counter. On equality, each compare register can flag an interrupt, return the counter to zero, or halt counting, in any combination.

Four asynchronous capture pins are first synchronised. An edge whose polarity software has selected then copies the counter into a per-pin capture register, and can also flag an interrupt. Eight sticky flags gather the interrupt sources: four from compares and four from captures. A single `irq_o` line reports whether any flag is pending. Software clears flags by writing ones to them.

Register word addresses are fixed:

| Address | Register |
|---|---|
| 0 | flags |
| 1 | control |
| 2 | counter |
| 3 | prescale limit |
| 4 | prescale count |
| 5 | compare actions |
| 6 to 9 | compare values 0 to 3 |
| 10 | capture config |
| 11 to 14 | captured values 0 to 3, read-only |

Reads are combinational from `reg_raddr_i`. Writes take effect on the clock edge where `reg_we_i` is high.

Top module: `mcap_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: While running, the prescale count steps 0,1,..,limit and then returns to 0. The counter increments only on that wrap, so it advances once per limit+1 clocks.
- R3: Control bit 0 is the run enable. When it is clear, the counter and the prescale count hold their values.
- R4: Control bit 1 is a hold-in-reset. While it is set, the counter and the prescale count are forced to 0 and bus writes to them are ignored.
- R5: A compare n fires only on a clock where the prescaler wraps while the counter equals compare value n. Action bit 3n (interrupt) then sets flag bit n.
- R6: Action bit 3n+1 (reset) makes the counter load 0 on the firing wrap instead of value+1.
- R7: Action bit 3n+2 (stop) clears control bit 0 on the firing wrap. The counter keeps the compare value and the prescale count is 0.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. `irq_o` is high exactly when some flag is set.
- R9: Capture config bit 3n selects rising edges of pin n and bit 3n+1 selects falling edges. A selected edge copies the counter into captured value n, and an unselected edge leaves it unchanged.
- R10: Capture config bit 3n+2 makes a capture on pin n set flag bit 4+n. Without it, no flag is set.
- R11: A pin change made between clock edges is captured on the third following edge, after a two-flop synchroniser and one edge-detect register.
- R12: The counter and the prescale count can be written and read back over the register port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Write strobe |
| reg_waddr_i | input | 4 | Write word address |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 4 | Read word address |
| reg_rdata_o | output | 32 | Read data, combinational |
| cap_i | input | 4 | Asynchronous capture pins |
| irq_o | output | 1 | Any interrupt flag pending |

## Verification
Register writes land on the edge inside the write strobe. Reads are combinational, so the monitor samples them half a nanosecond after setting the read address, well before the next edge. Counting tests enable the counter and then disable it again, exactly N edges apart. The bench then compares the stopped counter and prescale count with N/(limit+1) and N mod (limit+1). Capture results are due on the third edge after the pin moves. The bench reads the captured value once just before that edge, expecting 0, and once just after, expecting the frozen counter value. Compare flags and stop actions are read only once the counter has been stopped.

// File: rtl/mcap_timer_pkg.sv
`timescale 1ns/1ps
package mcap_timer_pkg;
  typedef struct packed {
    logic stop;
    logic rst;
    logic irq;
  } match_act_t;

  typedef struct packed {
    logic irq;
    logic fall;
    logic rise;
  } cap_cfg_t;

  localparam int unsigned A_FLAGS = 0;
  localparam int unsigned A_CTRL  = 1;
  localparam int unsigned A_TC    = 2;
  localparam int unsigned A_PR    = 3;
  localparam int unsigned A_PC    = 4;
  localparam int unsigned A_MCR   = 5;
  localparam int unsigned A_MR0   = 6;
endpackage

// File: rtl/mcap_prescaler.sv
`timescale 1ns/1ps
module mcap_prescaler #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] pc_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] pc_q;

  assign wrap_o = run_i && (pc_q == limit_i);
  assign pc_o   = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (clr_i)  pc_q <= '0;
    else if (wr_i)   pc_q <= wdata_i;
    else if (wrap_o) pc_q <= '0;
    else if (run_i)  pc_q <= pc_q + CNT_W'(1);
  end
endmodule

// File: rtl/mcap_match_unit.sv
`timescale 1ns/1ps
module mcap_match_unit
  import mcap_timer_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NUM_MATCH = 4
) (
  input  logic [CNT_W-1:0]                 tc_i,
  input  logic                             wrap_i,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0]  mr_i,
  input  match_act_t [NUM_MATCH-1:0]       act_i,
  output logic [NUM_MATCH-1:0]             irq_set_o,
  output logic                             tc_zero_o,
  output logic                             stop_o
);
  logic [NUM_MATCH-1:0] hit;
  logic [NUM_MATCH-1:0] zero_v;
  logic [NUM_MATCH-1:0] stop_v;

  for (genvar n = 0; n < NUM_MATCH; n++) begin : g_cmp
    assign hit[n]       = wrap_i && (tc_i == mr_i[n]);
    assign irq_set_o[n] = hit[n] && act_i[n].irq;
    assign zero_v[n]    = hit[n] && act_i[n].rst;
    assign stop_v[n]    = hit[n] && act_i[n].stop;
  end

  assign tc_zero_o = |zero_v;
  assign stop_o    = |stop_v;
endmodule

// File: rtl/mcap_capture_chan.sv
`timescale 1ns/1ps
module mcap_capture_chan
  import mcap_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  cap_cfg_t         cfg_i,
  input  logic [CNT_W-1:0] tc_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             irq_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              rise, fall, hit;
  logic [CNT_W-1:0]  cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pin_i};
      prev_q <= sync_q[SYNC_N-1];
    end
  end

  assign rise = sync_q[SYNC_N-1] && !prev_q;
  assign fall = !sync_q[SYNC_N-1] && prev_q;
  assign hit  = (rise && cfg_i.rise) || (fall && cfg_i.fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cap_q <= '0;
    else if (hit) cap_q <= tc_i;
  end

  assign cap_o = cap_q;
  assign irq_o = hit && cfg_i.irq;
endmodule

// File: rtl/mcap_timer.sv
`timescale 1ns/1ps
module mcap_timer
  import mcap_timer_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NUM_MATCH = 4,
  parameter int unsigned NUM_CAP   = 4,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_waddr_i,
  input  logic [CNT_W-1:0]     reg_wdata_i,
  input  logic [ADDR_W-1:0]    reg_raddr_i,
  output logic [CNT_W-1:0]     reg_rdata_o,
  input  logic [NUM_CAP-1:0]   cap_i,
  output logic                 irq_o
);
  localparam int unsigned NF     = NUM_MATCH + NUM_CAP;
  localparam int unsigned MCR_W  = 3 * NUM_MATCH;
  localparam int unsigned CCR_W  = 3 * NUM_CAP;
  localparam int unsigned A_CCR  = A_MR0 + NUM_MATCH;
  localparam int unsigned A_CAP0 = A_CCR + 1;

  logic                            ctrl_en_q, ctrl_rst_q;
  logic [CNT_W-1:0]                tc_q, pr_q, pc_q;
  match_act_t [NUM_MATCH-1:0]      mcr_q;
  logic [NUM_MATCH-1:0][CNT_W-1:0] mr_q;
  cap_cfg_t [NUM_CAP-1:0]          ccr_q;
  logic [NUM_CAP-1:0][CNT_W-1:0]   cap_val;
  logic [NUM_CAP-1:0]              cap_irq;
  logic [NUM_MATCH-1:0]            match_irq;
  logic [NF-1:0]                   flags_q, flag_clr;
  logic                            run, wrap, tc_zero, stop;

  function automatic logic wsel(input int unsigned a);
    return reg_we_i && (reg_waddr_i == ADDR_W'(a));
  endfunction

  assign run = ctrl_en_q && !ctrl_rst_q;

  mcap_prescaler #(.CNT_W(CNT_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctrl_rst_q),
    .run_i  (run),
    .limit_i(pr_q),
    .wr_i   (wsel(A_PC)),
    .wdata_i(reg_wdata_i),
    .pc_o   (pc_q),
    .wrap_o (wrap)
  );

  mcap_match_unit #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_match (
    .tc_i     (tc_q),
    .wrap_i   (wrap),
    .mr_i     (mr_q),
    .act_i    (mcr_q),
    .irq_set_o(match_irq),
    .tc_zero_o(tc_zero),
    .stop_o   (stop)
  );

  for (genvar c = 0; c < NUM_CAP; c++) begin : g_cap
    mcap_capture_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (cap_i[c]),
      .cfg_i (ccr_q[c]),
      .tc_i  (tc_q),
      .cap_o (cap_val[c]),
      .irq_o (cap_irq[c])
    );
  end

  // counter: hold-in-reset beats bus write beats counting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tc_q <= '0;
    else if (ctrl_rst_q) tc_q <= '0;
    else if (wsel(A_TC)) tc_q <= reg_wdata_i;
    else if (wrap) begin
      if (tc_zero)       tc_q <= '0;
      else if (!stop)    tc_q <= tc_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q  <= 1'b0;
      ctrl_rst_q <= 1'b0;
    end else if (wsel(A_CTRL)) begin
      ctrl_en_q  <= reg_wdata_i[0];
      ctrl_rst_q <= reg_wdata_i[1];
    end else if (stop) begin
      ctrl_en_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pr_q  <= '0;
      mcr_q <= '0;
      ccr_q <= '0;
    end else begin
      if (wsel(A_PR))  pr_q  <= reg_wdata_i;
      if (wsel(A_MCR)) mcr_q <= reg_wdata_i[MCR_W-1:0];
      if (wsel(A_CCR)) ccr_q <= reg_wdata_i[CCR_W-1:0];
    end
  end

  for (genvar m = 0; m < NUM_MATCH; m++) begin : g_mr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             mr_q[m] <= '0;
      else if (wsel(A_MR0+m))  mr_q[m] <= reg_wdata_i;
    end
  end

  // new events win over a same-cycle clear
  assign flag_clr = wsel(A_FLAGS) ? reg_wdata_i[NF-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~flag_clr) | {cap_irq, match_irq};
  end

  assign irq_o = |flags_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_raddr_i)
      ADDR_W'(A_FLAGS): reg_rdata_o = CNT_W'(flags_q);
      ADDR_W'(A_CTRL):  reg_rdata_o = CNT_W'({ctrl_rst_q, ctrl_en_q});
      ADDR_W'(A_TC):    reg_rdata_o = tc_q;
      ADDR_W'(A_PR):    reg_rdata_o = pr_q;
      ADDR_W'(A_PC):    reg_rdata_o = pc_q;
      ADDR_W'(A_MCR):   reg_rdata_o = CNT_W'(mcr_q);
      ADDR_W'(A_CCR):   reg_rdata_o = CNT_W'(ccr_q);
      default: begin
        for (int i = 0; i < NUM_MATCH; i++)
          if (reg_raddr_i == ADDR_W'(A_MR0 + i)) reg_rdata_o = mr_q[i];
        for (int i = 0; i < NUM_CAP; i++)
          if (reg_raddr_i == ADDR_W'(A_CAP0 + i)) reg_rdata_o = cap_val[i];
      end
    endcase
  end
endmodule

// File: rtl/mcap_timer_chk.sv
`timescale 1ns/1ps
module mcap_timer_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned NF    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic             en_i,
  input logic             hold_i,
  input logic [CNT_W-1:0] tc_i,
  input logic [CNT_W-1:0] pc_i,
  input logic [CNT_W-1:0] pr_i,
  input logic [NF-1:0]    flags_i,
  input logic             irq_i
);
  p_hold_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (tc_i == '0) && (pc_i == '0));

  p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !hold_i && !reg_we_i) |=> $stable(tc_i) && $stable(pc_i));

  p_pc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !hold_i && !reg_we_i && pc_i != pr_i)
      |=> (pc_i == $past(pc_i) + CNT_W'(1)) && $stable(tc_i));

  p_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_i) |-> $past(reg_we_i) || (pc_i == '0));

  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && irq_i) |=> irq_i && ($countones(flags_i) >= $countones($past(flags_i))));
endmodule

bind mcap_timer mcap_timer_chk #(.CNT_W(CNT_W), .NF(NF)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .reg_we_i(reg_we_i),
  .en_i    (ctrl_en_q),
  .hold_i  (ctrl_rst_q),
  .tc_i    (tc_q),
  .pc_i    (pc_q),
  .pr_i    (pr_q),
  .flags_i (flags_q),
  .irq_i   (irq_o)
);

// File: tb/sim_mcap_timer.sv
`timescale 1ns/1ps
module sim_mcap_timer;
  localparam int A_FLAGS = 0, A_CTRL = 1, A_TC = 2, A_PR = 3, A_PC = 4,
                 A_MCR = 5, A_MR0 = 6, A_CCR = 10, A_CAP0 = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  raddr = '0;
  logic [31:0] rdata;
  logic [3:0]  cap = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [3:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  mcap_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_waddr_i(waddr),
    .reg_wdata_i(wdata), .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .cap_i(cap), .irq_o(irq)
  );

  // monitor: pops expected items and compares against the read port
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() != 0) begin
        item_t it;
        logic [31:0] act;
        it = q[0];
        raddr = it.addr;
        #0.5;
        act = it.is_irq ? {31'd0, irq} : rdata;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s addr=%0d actual=0x%0h expected=0x%0h", it.tag, it.addr, act, it.exp);
        end
        void'(q.pop_front());
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = 4'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int a, input logic [31:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b0; it.addr = 4'(a); it.exp = e; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.addr = '0; it.exp = {31'd0, e}; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  // enable, then disable exactly 'steps' edges of counting later (steps >= 2)
  task automatic run(input int steps);
    wr(A_CTRL, 32'd1);
    idle(steps - 2);
    wr(A_CTRL, 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk(A_FLAGS, 0, "R1 flags");
    chk(A_CTRL, 0, "R1 ctrl");
    chk(A_TC, 0, "R1 tc");
    chk(A_PC, 0, "R1 pc");
    chk(A_CAP0, 0, "R1 cap0");
    chk_irq(1'b0, "R1 irq");

    // R12 bus access to counters
    wr(A_TC, 32'd1234);
    wr(A_PC, 32'd7);
    chk(A_TC, 32'd1234, "R12 tc rw");
    chk(A_PC, 32'd7, "R12 pc rw");

    // R2 prescale divide by 3, 11 steps
    wr(A_TC, 0); wr(A_PC, 0); wr(A_PR, 2);
    run(11);
    chk(A_TC, 3, "R2 tc pr2");
    chk(A_PC, 2, "R2 pc pr2");
    // R3 disabled holds
    idle(5);
    chk(A_TC, 3, "R3 tc held");
    chk(A_PC, 2, "R3 pc held");

    // R2 no prescale
    wr(A_PR, 0); wr(A_TC, 0); wr(A_PC, 0);
    run(7);
    chk(A_TC, 7, "R2 tc pr0");

    // R5 compare only on wrap
    wr(A_PR, 3); wr(A_TC, 2); wr(A_PC, 0);
    wr(A_MCR, 32'h1); wr(A_MR0, 2);
    run(3);
    chk(A_FLAGS, 0, "R5 no wrap no flag");
    run(2);
    chk(A_FLAGS, 32'h1, "R5 flag0");
    chk(A_TC, 3, "R5 tc");
    chk(A_PC, 1, "R5 pc");
    chk_irq(1'b1, "R8 irq high");
    // R8 write-one-to-clear
    wr(A_FLAGS, 32'h0);
    chk(A_FLAGS, 32'h1, "R8 zero no effect");
    wr(A_FLAGS, 32'h1);
    chk(A_FLAGS, 0, "R8 cleared");
    chk_irq(1'b0, "R8 irq low");

    // R5 compare 2 sets flag bit 2
    wr(A_PR, 0); wr(A_TC, 3); wr(A_PC, 0);
    wr(A_MCR, 32'h40); wr(A_MR2, 5);
    run(5);
    chk(A_TC, 8, "R5 tc after m2");
    chk(A_FLAGS, 32'h4, "R5 flag2");
    wr(A_FLAGS, 32'hFF);

    // R6 reset on compare 0 at 4
    wr(A_PR, 1); wr(A_TC, 0); wr(A_PC, 0);
    wr(A_MCR, 32'h2); wr(A_MR0, 4);
    run(23);
    chk(A_TC, 1, "R6 tc wraps at 4");
    chk(A_PC, 1, "R6 pc");
    chk(A_FLAGS, 0, "R6 no irq action");

    // R7 stop on compare 1 at 3
    wr(A_TC, 0); wr(A_PC, 0);
    wr(A_MCR, 32'h20); wr(A_MR0 + 1, 3);
    wr(A_CTRL, 32'd1);
    idle(20);
    chk(A_CTRL, 0, "R7 enable cleared");
    chk(A_TC, 3, "R7 tc held at match");
    chk(A_PC, 0, "R7 pc zero");

    // R4 hold in reset
    wr(A_TC, 50);
    wr(A_CTRL, 32'd3);
    wr(A_TC, 77); wr(A_PC, 9);
    idle(3);
    chk(A_TC, 0, "R4 tc forced zero");
    chk(A_PC, 0, "R4 pc forced zero");
    wr(A_CTRL, 32'd0);
    wr(A_MCR, 0);

    // capture: ch0 rise+irq, ch1 fall, ch2 both, ch3 none
    wr(A_CCR, 32'hD5);
    wr(A_TC, 100);
    @(negedge clk); cap[0] = 1'b1;
    idle(2);
    chk(A_CAP0, 0, "R11 not before third edge");
    chk(A_CAP0, 100, "R11 R9 cap0 rise");
    chk(A_FLAGS, 32'h10, "R10 flag4");

    wr(A_TC, 200);
    @(negedge clk); cap[1] = 1'b1;
    idle(5);
    chk(A_CAP0 + 1, 0, "R9 rise unselected");
    @(negedge clk); cap[1] = 1'b0;
    idle(5);
    chk(A_CAP0 + 1, 200, "R9 cap1 fall");
    chk(A_FLAGS, 32'h10, "R10 no flag without enable");

    wr(A_TC, 300);
    @(negedge clk); cap[2] = 1'b1;
    idle(5);
    chk(A_CAP0 + 2, 300, "R9 cap2 rise");
    wr(A_TC, 400);
    @(negedge clk); cap[2] = 1'b0;
    idle(5);
    chk(A_CAP0 + 2, 400, "R9 cap2 fall");

    @(negedge clk); cap[3] = 1'b1;
    idle(5);
    @(negedge clk); cap[3] = 1'b0;
    idle(5);
    chk(A_CAP0 + 3, 0, "R9 cap3 disabled");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam int A_MR2 = A_MR0 + 2;
endmodule